// File: doc/BRIEF.md
# Signal Quality Index Capture Unit

This block sits beside an Ethernet PHY receiver and turns the mean-square-error figures that the receiver produces for each of its four cable pairs into a 3-bit quality grade. The grade is 7 for a clean signal and falls toward 0 as the error grows. It is found by counting how many entries of a seven-entry programmable threshold table the error reaches.

Software drives the block through a small word-wide register bus. It turns the grading on and picks a cable pair. It then issues a one-shot capture command. The captured grade appears in a status word, together with the lowest grade seen since the status word was last read and a flag showing that no error sample has yet arrived for the chosen pair. Reading the status word starts a new worst-case window.

Top module: `sqi_capture`

## Requirements
- R1: A capture stores the grade 7 minus the number of thresholds for which the held error of the chosen pair is greater than or equal to the threshold. This is an unsigned 16-bit compare, and the grade lands in status bits [2:0].
- R2: After a synchronous active-high reset, the configuration word and the status word read 0, and threshold k (0..6) reads 8192*(k+1).
- R3: While the enable bit (configuration bit 0) is clear, the status word reads 0 and a capture command changes nothing.
- R4: The capture command is configuration bit 3. Written as 1 together with enable, it reads back as 1 for exactly one cycle and then clears itself.
- R5: The captured result is visible in the status word from the cycle after the capture bit reads 1.
- R6: Configuration bits [2:1] choose the pair. A capture uses the most recent valid error sample of that pair only.
- R7: Status bits [6:4] hold the lowest grade captured since the last status read, or 7 if there has been none.
- R8: A status read returns the value held before the read edge. After that edge, the worst field is 7, or it is the grade captured on that same edge.
- R9: Status bit 8 is set when a capture finds no valid sample for the chosen pair since enable. In that case the grade and worst fields are left unchanged. A capture that finds a sample clears the bit.
- R10: Thresholds 0..6 are read and written at offsets 2..8. Offsets 9..15 read 0, and writes to them are ignored.
- R11: Error samples that arrive while the block is disabled are discarded. Disabling the block forgets all earlier samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mseIn | input | 64 | Four 16-bit error samples, pair n in bits [16n+15:16n] |
| mseValid | input | 4 | Per-pair sample strobe |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (status read clears the worst field) |
| regAddr | input | 4 | Register offset |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data, combinational from regAddr |

## Verification
The hardest case to reach is a status read that falls on the same clock edge as the capture it would otherwise hide. The read must return the old worst grade, and the worst field must then restart from the new grade instead of 7. The stimulus reaches this case by placing the read strobe in the one cycle in which the self-clearing capture bit is high. A second hard case is a capture of a pair that has had no sample since the last re-enable. Random stimulus reaches it by toggling enable between sample bursts that skip some pairs.

// File: rtl/sqi_pkg.sv
package sqi_pkg;
  localparam int NUM_CH = 4;
  localparam int MSE_W  = 16;
  localparam int IDX_W  = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int CH_W   = $clog2(NUM_CH);
  localparam int NUM_TH = (1 << IDX_W) - 1;
  localparam int TH_SEL_W = $clog2(NUM_TH);
  localparam int CFG_ADDR = 0;
  localparam int STAT_ADDR = 1;
  localparam int TH_BASE = 2;
  localparam int CAP_BIT = CH_W + 1;
  localparam int NR_BIT  = 8;
  localparam int WORST_LSB = 4;

  typedef struct packed {
    logic                enable;
    logic                capture;
    logic [CH_W-1:0]     chan;
    logic                statusRead;
    logic                thrWrite;
    logic [TH_SEL_W-1:0] thrSel;
    logic [MSE_W-1:0]    wrData;
  } sqi_strobe_t;

  function automatic logic [MSE_W-1:0] defaultThr(input int k);
    return MSE_W'((k + 1) << (MSE_W - IDX_W));
  endfunction
endpackage

// File: rtl/sqi_ctrl.sv
module sqi_ctrl
  import sqi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  input  logic [DATA_W-1:0]       statusWord,
  input  logic [NUM_TH*MSE_W-1:0] thrFlat,
  output logic [DATA_W-1:0]       regRdData,
  output sqi_strobe_t             strb
);
  localparam int TH_LAST = TH_BASE + NUM_TH - 1;

  logic            enReg;
  logic [CH_W-1:0] chanReg;
  logic            capReq;
  logic            cfgHit;
  logic            thrHit;
  logic [ADDR_W-1:0] thrOff;

  assign cfgHit = (regAddr == ADDR_W'(CFG_ADDR));
  assign thrHit = (regAddr >= ADDR_W'(TH_BASE)) && (regAddr <= ADDR_W'(TH_LAST));
  assign thrOff = regAddr - ADDR_W'(TH_BASE);

  always_ff @(posedge clk) begin
    if (rst) begin
      enReg   <= 1'b0;
      chanReg <= '0;
      capReq  <= 1'b0;
    end else begin
      capReq <= 1'b0;
      if (regWrEn && cfgHit) begin
        enReg   <= regWrData[0];
        chanReg <= regWrData[CH_W:1];
        capReq  <= regWrData[0] & regWrData[CAP_BIT];
      end
    end
  end

  always_comb begin
    strb.enable     = enReg;
    strb.capture    = capReq;
    strb.chan       = chanReg;
    strb.statusRead = regRdEn && (regAddr == ADDR_W'(STAT_ADDR));
    strb.thrWrite   = regWrEn && thrHit;
    strb.thrSel     = TH_SEL_W'(thrOff);
    strb.wrData     = regWrData[MSE_W-1:0];
  end

  always_comb begin
    regRdData = '0;
    if (cfgHit) begin
      regRdData[0]       = enReg;
      regRdData[CH_W:1]  = chanReg;
      regRdData[CAP_BIT] = capReq;
    end else if (regAddr == ADDR_W'(STAT_ADDR)) begin
      regRdData = statusWord;
    end else if (thrHit) begin
      regRdData = DATA_W'(thrFlat[thrOff*MSE_W +: MSE_W]);
    end
  end

  // capture command lasts one cycle only
  p_cap_selfclear_r4: assert property (@(posedge clk) disable iff (rst)
    capReq |=> !capReq);
  // a capture can only be pending while enabled
  p_cap_needs_en_r3: assert property (@(posedge clk) disable iff (rst)
    capReq |-> enReg);
endmodule

// File: rtl/sqi_datapath.sv
module sqi_datapath
  import sqi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  sqi_strobe_t             strb,
  input  logic [NUM_CH*MSE_W-1:0] mseIn,
  input  logic [NUM_CH-1:0]       mseValid,
  output logic [DATA_W-1:0]       statusWord,
  output logic [NUM_TH*MSE_W-1:0] thrFlat
);
  localparam logic [IDX_W-1:0] IDX_MAX = IDX_W'(NUM_TH);

  logic [MSE_W-1:0]  thr     [NUM_TH];
  logic [MSE_W-1:0]  mseHold [NUM_CH];
  logic [NUM_CH-1:0] seen;
  logic [NUM_TH-1:0] hit;
  logic [MSE_W-1:0]  selMse;
  logic [IDX_W-1:0]  hitCount;
  logic [IDX_W-1:0]  newIdx;
  logic              capGood;
  logic [IDX_W-1:0]  curIdx;
  logic [IDX_W-1:0]  worstIdx;
  logic              notReady;

  for (genvar k = 0; k < NUM_TH; k++) begin : g_thr
    always_ff @(posedge clk) begin
      if (rst)
        thr[k] <= defaultThr(k);
      else if (strb.thrWrite && strb.thrSel == TH_SEL_W'(k))
        thr[k] <= strb.wrData;
    end
    assign thrFlat[k*MSE_W +: MSE_W] = thr[k];
    assign hit[k] = (selMse >= thr[k]);
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    always_ff @(posedge clk) begin
      if (rst) begin
        mseHold[c] <= '0;
        seen[c]    <= 1'b0;
      end else if (!strb.enable) begin
        seen[c] <= 1'b0;
      end else if (mseValid[c]) begin
        mseHold[c] <= mseIn[c*MSE_W +: MSE_W];
        seen[c]    <= 1'b1;
      end
    end
  end

  assign selMse = mseHold[strb.chan];

  always_comb begin
    hitCount = '0;
    for (int k = 0; k < NUM_TH; k++)
      hitCount = hitCount + IDX_W'(hit[k]);
  end

  assign newIdx  = IDX_MAX - hitCount;
  assign capGood = strb.enable && strb.capture && seen[strb.chan];

  always_ff @(posedge clk) begin
    if (rst || !strb.enable) begin
      curIdx   <= '0;
      worstIdx <= IDX_MAX;
      notReady <= 1'b1;
    end else begin
      if (capGood) begin
        curIdx   <= newIdx;
        notReady <= 1'b0;
      end else if (strb.capture) begin
        notReady <= 1'b1;
      end
      if (strb.statusRead)
        worstIdx <= capGood ? newIdx : IDX_MAX;
      else if (capGood && newIdx < worstIdx)
        worstIdx <= newIdx;
    end
  end

  always_comb begin
    statusWord = '0;
    if (strb.enable) begin
      statusWord[IDX_W-1:0]                 = curIdx;
      statusWord[WORST_LSB +: IDX_W]        = worstIdx;
      statusWord[NR_BIT]                    = notReady;
    end
  end

  // after a good capture without a read, worst cannot exceed current
  p_worst_bound_r7: assert property (@(posedge clk) disable iff (rst)
    (capGood && !strb.statusRead) |=> (worstIdx <= curIdx));
  // read without capture restarts the worst window at the top grade
  p_read_clear_r8: assert property (@(posedge clk) disable iff (rst)
    (strb.enable && strb.statusRead && !strb.capture) |=> (worstIdx == IDX_MAX));
  // capture of an unsampled pair raises not-ready
  p_not_ready_r9: assert property (@(posedge clk) disable iff (rst)
    (strb.enable && strb.capture && !seen[strb.chan]) |=> notReady);
  // disabled block holds cleared state
  p_disabled_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !strb.enable |=> (curIdx == '0 && notReady && seen == '0));
endmodule

// File: rtl/sqi_capture.sv
module sqi_capture
  import sqi_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_CH*MSE_W-1:0] mseIn,
  input  logic [NUM_CH-1:0]       mseValid,
  input  logic                    regWrEn,
  input  logic                    regRdEn,
  input  logic [ADDR_W-1:0]       regAddr,
  input  logic [DATA_W-1:0]       regWrData,
  output logic [DATA_W-1:0]       regRdData
);
  sqi_strobe_t             strb;
  logic [DATA_W-1:0]       statusWord;
  logic [NUM_TH*MSE_W-1:0] thrFlat;

  sqi_ctrl u_ctrl (
    .clk(clk), .rst(rst), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .statusWord(statusWord),
    .thrFlat(thrFlat), .regRdData(regRdData), .strb(strb)
  );

  sqi_datapath u_dp (
    .clk(clk), .rst(rst), .strb(strb), .mseIn(mseIn), .mseValid(mseValid),
    .statusWord(statusWord), .thrFlat(thrFlat)
  );
endmodule

// File: tb/tb_sqi_capture.sv
module tb_sqi_capture;
  logic        clk = 1'b0;
  logic        rst;
  logic [63:0] mseIn;
  logic [3:0]  mseValid;
  logic        regWrEn, regRdEn;
  logic [3:0]  regAddr;
  logic [15:0] regWrData;
  logic [15:0] regRdData;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [15:0] thM  [7];
  logic [15:0] mseM [4];
  bit          seenM[4];
  bit          enM;
  logic [1:0]  chM;
  logic [2:0]  curM, worstM;
  bit          nrM;

  always #10 clk = ~clk;

  sqi_capture dut (.*);

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [2:0] expIdx(input logic [15:0] m);
    int c = 0;
    for (int k = 0; k < 7; k++) if (m >= thM[k]) c++;
    return 3'(7 - c);
  endfunction

  function automatic logic [15:0] expStatus();
    if (!enM) return 16'h0;
    return {7'd0, nrM, 1'b0, worstM, 1'b0, curM};
  endfunction

  function automatic void modelCapture();
    if (seenM[chM]) begin
      logic [2:0] i = expIdx(mseM[chM]);
      curM = i; nrM = 0;
      if (i < worstM) worstM = i;
    end else nrM = 1;
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    regAddr = a; regWrData = d; regWrEn = 1;
    @(negedge clk);
    regWrEn = 0;
    if (a >= 2 && a <= 8) thM[a-2] = d;
  endtask

  task automatic rdCheck(input logic [3:0] a, input logic [15:0] exp, input string tag);
    regAddr = a; regRdEn = 1;
    #1 check(regRdData, exp, tag);
    @(negedge clk);
    regRdEn = 0;
    if (a == 1 && enM) worstM = 3'd7;
  endtask

  task automatic cfg(input bit en, input logic [1:0] ch, input bit cap);
    wr(4'd0, {12'd0, cap, ch, en});
    if (!enM || !en) begin
      for (int c = 0; c < 4; c++) seenM[c] = 0;
      curM = 0; worstM = 7; nrM = 1;
    end
    enM = en; chM = ch;
    if (cap && en) begin
      #1 check(regRdData & 16'h8, 16'h8, "R4 capture bit high");
      @(negedge clk);
      modelCapture();
      #1 check(regRdData & 16'h8, 16'h0, "R4 capture bit cleared");
    end
  endtask

  task automatic push(input logic [3:0] mask, input logic [63:0] vals);
    mseIn = vals; mseValid = mask;
    @(negedge clk);
    mseValid = 0;
    if (enM) for (int c = 0; c < 4; c++) if (mask[c]) begin
      mseM[c] = vals[c*16 +: 16]; seenM[c] = 1;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(1234));
    rst = 1; mseIn = 0; mseValid = 0; regWrEn = 0; regRdEn = 0; regAddr = 0; regWrData = 0;
    for (int k = 0; k < 7; k++) thM[k] = 16'((k + 1) * 8192);
    for (int c = 0; c < 4; c++) begin mseM[c] = 0; seenM[c] = 0; end
    enM = 0; chM = 0; curM = 0; worstM = 7; nrM = 1;
    repeat (3) @(negedge clk);
    rst = 0;

    rdCheck(4'd0, 16'h0, "R2 config reset");
    rdCheck(4'd1, 16'h0, "R2 status reset");
    for (int k = 0; k < 7; k++) rdCheck(4'(k + 2), 16'((k + 1) * 8192), "R2 threshold reset");

    // R3: capture while disabled
    push(4'hF, {4{16'h0100}});
    cfg(0, 2'd1, 1);
    rdCheck(4'd1, 16'h0, "R3 disabled status zero");

    // R9 / R11: enable, capture pair with no sample (earlier sample discarded)
    cfg(1, 2'd1, 0);
    cfg(1, 2'd1, 1);
    rdCheck(4'd1, expStatus(), "R9 R11 not ready");

    // R1 boundaries: exactly on a threshold, zero, max
    push(4'b0010, {16'd0, 16'd0, 16'd8192, 16'd0});
    cfg(1, 2'd1, 1);
    rdCheck(4'd1, expStatus(), "R1 equal to threshold");
    push(4'b0001, {48'd0, 16'hFFFF});
    cfg(1, 2'd0, 1);
    rdCheck(4'd1, expStatus(), "R1 R6 max error grade 0");
    push(4'b0100, {16'd0, 16'd0, 16'd0, 16'd0});
    cfg(1, 2'd2, 1);
    rdCheck(4'd1, expStatus(), "R1 zero error grade 7");

    // R8: read on the same edge as the capture
    push(4'b0001, {48'd0, 16'd20000});
    cfg(1, 2'd0, 1);
    cfg(1, 2'd3, 0);
    push(4'b1000, {16'd30000, 48'd0});
    wr(4'd0, {12'd0, 1'b1, 2'd3, 1'b1});
    regAddr = 4'd1; regRdEn = 1;
    #1 check(regRdData, expStatus(), "R8 same-edge read old value");
    @(negedge clk);
    regRdEn = 0;
    modelCapture();
    worstM = curM;
    rdCheck(4'd1, expStatus(), "R8 worst restarts at captured grade");

    // R10: unmapped offset
    wr(4'd12, 16'h1234);
    rdCheck(4'd12, 16'h0, "R10 unmapped reads zero");
    for (int k = 0; k < 7; k++) rdCheck(4'(k + 2), thM[k], "R10 unmapped write ignored");

    // random phase
    for (int it = 0; it < 400; it++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [63:0] v;
        for (int c = 0; c < 4; c++) v[c*16 +: 16] = 16'($urandom);
        push(4'($urandom), v);
      end else if (op < 6) begin
        cfg(1, 2'($urandom), 1);
      end else if (op < 8) begin
        rdCheck(4'd1, expStatus(), "R5 R6 R7 random status");
      end else if (op == 8) begin
        int k = $urandom_range(0, 6);
        wr(4'(k + 2), 16'($urandom));
        rdCheck(4'(k + 2), thM[k], "R10 threshold readback");
      end else begin
        cfg($urandom_range(0, 3) != 0, chM, 0);
      end
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule